// File: doc/BRIEF.md
# Atomic Operand Exchange Unit

This execution unit carries out an operand swap between two general registers, or between one general register and a memory operand. It accepts a one-byte short form that trades a register with the accumulator, and a two-byte form whose second byte (the addressing byte) picks a byte, word or doubleword register pair or a register and a memory location. Register reads are combinational through two read ports. All register updates go through a single write port, and a byte or word update is merged into the full 32-bit register so that the untouched bits survive.

A memory swap is always atomic. The unit first checks the memory operand against the segment attributes it was given. If that check passes, it holds the bus lock from the start of the read request until the write is acknowledged. Only after that acknowledgement does it write the register. If the check fails, the unit raises a fault and leaves both the registers and memory as they were. Address generation, prefix decoding and status flags are outside the unit; it has no path to the flags at all.

States are `ST_IDLE`, `ST_RR_WR_A`, `ST_RR_WR_B`, `ST_CHECK`, `ST_LK_RD`, `ST_LK_WR`, `ST_REG_WB`, `ST_COMPLETE` and `ST_FAULT`. The transitions are:
- IDLE to RR_WR_A, on an accepted register form.
- IDLE to CHECK, on an accepted memory form.
- RR_WR_A to RR_WR_B to COMPLETE.
- CHECK to FAULT when the check fails, otherwise CHECK to LK_RD.
- LK_RD to LK_WR on the read acknowledge.
- LK_WR to REG_WB on the write acknowledge.
- REG_WB to COMPLETE.
- COMPLETE to IDLE, and FAULT to IDLE.

Top module: `xchg_unit`

## Requirements
- R1: Opcode 0x90+r (r in 0..7) swaps register r with register 0. With `opsize32`=0 only bits 15:0 of each register are exchanged and bits 31:16 are kept. With `opsize32`=1 all 32 bits are exchanged.
- R2: Opcode 0x86 with addressing bits 7:6 = 3 swaps the byte operand named by bits 5:3 with the one named by bits 2:0. Byte numbers 0..3 are bits 7:0 of registers 0..3, and byte numbers 4..7 are bits 15:8 of registers 0..3. All other bits are kept. Two bytes of the same register (for example 0 and 4) are swapped correctly.
- R3: Opcode 0x87 with addressing bits 7:6 = 3 swaps registers bits 5:3 and bits 2:0. The swap covers 16 bits when `opsize32`=0 and 32 bits when `opsize32`=1.
- R4: Opcode 0x86 or 0x87 with addressing bits 7:6 other than 3 runs a memory swap. The unit reads at `mem_offset` with `mem_size` (0 byte, 1 word, 2 doubleword). It then writes the old register part to the same address. The register named by bits 5:3 then receives the value read.
- R5: During a memory swap, `bus_lock` is high in every cycle from the read request through the cycle of the write acknowledge, and low otherwise.
- R6: `done` pulses for one cycle. For a register swap it comes 3 cycles after the start edge. For a memory swap it comes 5 cycles after the start edge with no memory wait, plus the wait cycles of both accesses.
- R7: In protected mode (`real_mode`=0), a non-writable segment raises `fault` with `fault_vec`=13.
- R8: In real mode, the unit raises `fault` with vector 13 if the last byte of the operand is past 0xFFFF. Segment writability is ignored in real mode.
- R9: In protected mode, the unit raises a fault if the last byte of the operand is past `seg_limit`. The vector is 12 if `seg_is_stack` is set, and 13 otherwise.
- R10: A fault pulses 2 cycles after the start edge. A faulting swap makes no register write, no memory request and no lock.
- R11: A start with any other opcode is ignored.
- R12: Swapping a register with itself leaves every register unchanged and completes as a normal register swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a swap (sampled in idle) |
| opcode | input | 8 | First instruction byte |
| modrm | input | 8 | Addressing byte |
| opsize32 | input | 1 | Operand size 32 when set, 16 when clear |
| real_mode | input | 1 | Real-address mode |
| seg_writable | input | 1 | Memory operand segment is writable |
| seg_is_stack | input | 1 | Memory operand is in the stack segment |
| seg_limit | input | ADDR_W | Highest valid offset (protected mode) |
| mem_offset | input | ADDR_W | Memory operand offset |
| rf_raddr_a | output | 3 | Read address, first operand register |
| rf_raddr_b | output | 3 | Read address, second operand register |
| rf_rdata_a | input | 32 | Read data, first port |
| rf_rdata_b | input | 32 | Read data, second port |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write address |
| rf_wdata | output | 32 | Full merged register write value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Access offset |
| mem_size | output | 2 | 0 byte, 1 word, 2 doubleword |
| mem_wdata | output | 32 | Write data, low-aligned |
| mem_rdata | input | 32 | Read data, low-aligned |
| mem_ack | input | 1 | Access acknowledge |
| bus_lock | output | 1 | Bus lock |
| done | output | 1 | Swap complete pulse |
| fault | output | 1 | Fault pulse |
| fault_vec | output | 8 | Fault vector (valid with fault) |

## Verification
Two pairs of events can fall in the same cycle. First, the write acknowledge ends the locked pair in the same cycle that decides the lock release. Second, in a byte swap of two halves of one register, both updates target the same register. The bench sweeps memory swaps with zero and two wait cycles per access, counts the cycles in which the lock is high, and requires that count to equal both access windows with no request ever seen unlocked. Every pairing of byte operands, including the same-register pairs, is swept against an arithmetic register model. The resulting full register file is compared after each swap.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    localparam int DW = 32;
    localparam logic [7:0] VEC_GP = 8'd13;
    localparam logic [7:0] VEC_SS = 8'd12;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_D = 2'd2
    } opsz_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RR_WR_A,
        ST_RR_WR_B,
        ST_CHECK,
        ST_LK_RD,
        ST_LK_WR,
        ST_REG_WB,
        ST_COMPLETE,
        ST_FAULT
    } state_e;

    // Pull the addressed operand out of a full register, low-aligned.
    function automatic logic [DW-1:0] opnd_get(input logic [DW-1:0] full,
                                               input opsz_e sz,
                                               input logic hi);
        logic [DW-1:0] r;
        case (sz)
            SZ_B:    r = hi ? {24'b0, full[15:8]} : {24'b0, full[7:0]};
            SZ_W:    r = {16'b0, full[15:0]};
            default: r = full;
        endcase
        return r;
    endfunction

    // Merge a low-aligned operand value back into a full register.
    function automatic logic [DW-1:0] opnd_put(input logic [DW-1:0] full,
                                               input logic [DW-1:0] val,
                                               input opsz_e sz,
                                               input logic hi);
        logic [DW-1:0] r;
        case (sz)
            SZ_B:    r = hi ? {full[31:16], val[7:0], full[7:0]}
                            : {full[31:8], val[7:0]};
            SZ_W:    r = {full[31:16], val[15:0]};
            default: r = val;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xchg_decode.sv
module xchg_decode
    import xchg_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] modrm,
    input  logic       opsize32,
    output logic       valid,
    output opsz_e      sz,
    output logic       is_mem,
    output logic [2:0] a_phys,
    output logic       a_hi,
    output logic [2:0] b_phys,
    output logic       b_hi
);
    logic [2:0] a_idx;
    logic [2:0] b_idx;

    always_comb begin
        valid  = 1'b0;
        sz     = opsize32 ? SZ_D : SZ_W;
        is_mem = 1'b0;
        a_idx  = 3'd0;
        b_idx  = 3'd0;
        if (opcode[7:3] == 5'b10010) begin
            valid = 1'b1;
            b_idx = opcode[2:0];
        end else if (opcode == 8'h86 || opcode == 8'h87) begin
            valid  = 1'b1;
            if (opcode == 8'h86) sz = SZ_B;
            is_mem = (modrm[7:6] != 2'b11);
            a_idx  = modrm[5:3];
            b_idx  = modrm[2:0];
        end
    end

    always_comb begin
        if (sz == SZ_B) begin
            a_phys = {1'b0, a_idx[1:0]};
            a_hi   = a_idx[2];
            b_phys = {1'b0, b_idx[1:0]};
            b_hi   = b_idx[2];
        end else begin
            a_phys = a_idx;
            a_hi   = 1'b0;
            b_phys = b_idx;
            b_hi   = 1'b0;
        end
    end

endmodule

// File: rtl/xchg_fault_chk.sv
module xchg_fault_chk
    import xchg_pkg::*;
#(
    parameter int ADDR_W = 32
)(
    input  logic [ADDR_W-1:0] addr,
    input  opsz_e             sz,
    input  logic              real_mode,
    input  logic              writable,
    input  logic              is_stack,
    input  logic [ADDR_W-1:0] limit,
    output logic              flt,
    output logic [7:0]        vec
);
    localparam logic [ADDR_W:0] RM_TOP = {{(ADDR_W-16){1'b0}}, 17'h0FFFF};

    logic [ADDR_W:0] span;
    logic [ADDR_W:0] last;

    always_comb begin
        case (sz)
            SZ_B:    span = '0;
            SZ_W:    span = {{ADDR_W{1'b0}}, 1'b1};
            default: span = {{(ADDR_W-1){1'b0}}, 2'b11};
        endcase
        last = {1'b0, addr} + span;
    end

    always_comb begin
        flt = 1'b0;
        vec = VEC_GP;
        if (real_mode) begin
            flt = (last > RM_TOP);
        end else if (!writable) begin
            flt = 1'b1;
        end else if (last > {1'b0, limit}) begin
            flt = 1'b1;
            vec = is_stack ? VEC_SS : VEC_GP;
        end
    end

endmodule

// File: rtl/xchg_unit.sv
module xchg_unit
    import xchg_pkg::*;
#(
    parameter int ADDR_W = 32
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [7:0]        modrm,
    input  logic              opsize32,
    input  logic              real_mode,
    input  logic              seg_writable,
    input  logic              seg_is_stack,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic [ADDR_W-1:0] mem_offset,
    output logic [2:0]        rf_raddr_a,
    output logic [2:0]        rf_raddr_b,
    input  logic [31:0]       rf_rdata_a,
    input  logic [31:0]       rf_rdata_b,
    output logic              rf_we,
    output logic [2:0]        rf_waddr,
    output logic [31:0]       rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              bus_lock,
    output logic              done,
    output logic              fault,
    output logic [7:0]        fault_vec
);
    state_e state, nstate;

    logic       dec_valid, dec_mem, dec_ahi, dec_bhi;
    opsz_e      dec_sz;
    logic [2:0] dec_pa, dec_pb;

    opsz_e             sz_q;
    logic [2:0]        pa_q, pb_q;
    logic              ha_q, hb_q;
    logic [DW-1:0]     va_q, vb_q, mem_q;
    logic [ADDR_W-1:0] addr_q, lim_q;
    logic              rm_q, wr_q, stk_q;
    logic [7:0]        vec_q;

    logic              chk_flt;
    logic [7:0]        chk_vec;
    logic              go;
    logic [DW-1:0]     wr_a_val;

    xchg_decode u_dec (
        .opcode   (opcode),
        .modrm    (modrm),
        .opsize32 (opsize32),
        .valid    (dec_valid),
        .sz       (dec_sz),
        .is_mem   (dec_mem),
        .a_phys   (dec_pa),
        .a_hi     (dec_ahi),
        .b_phys   (dec_pb),
        .b_hi     (dec_bhi)
    );

    xchg_fault_chk #(.ADDR_W(ADDR_W)) u_chk (
        .addr      (addr_q),
        .sz        (sz_q),
        .real_mode (rm_q),
        .writable  (wr_q),
        .is_stack  (stk_q),
        .limit     (lim_q),
        .flt       (chk_flt),
        .vec       (chk_vec)
    );

    assign rf_raddr_a = dec_pa;
    assign rf_raddr_b = dec_pb;
    assign go         = start && dec_valid;
    assign wr_a_val   = opnd_put(va_q, opnd_get(vb_q, sz_q, hb_q), sz_q, ha_q);
    assign mem_addr   = addr_q;
    assign mem_size   = sz_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Operand and attribute capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sz_q   <= SZ_B;
            pa_q   <= '0;
            pb_q   <= '0;
            ha_q   <= 1'b0;
            hb_q   <= 1'b0;
            va_q   <= '0;
            vb_q   <= '0;
            mem_q  <= '0;
            addr_q <= '0;
            lim_q  <= '0;
            rm_q   <= 1'b0;
            wr_q   <= 1'b0;
            stk_q  <= 1'b0;
            vec_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (go) begin
                    sz_q   <= dec_sz;
                    pa_q   <= dec_pa;
                    pb_q   <= dec_pb;
                    ha_q   <= dec_ahi;
                    hb_q   <= dec_bhi;
                    va_q   <= rf_rdata_a;
                    vb_q   <= rf_rdata_b;
                    addr_q <= mem_offset;
                    lim_q  <= seg_limit;
                    rm_q   <= real_mode;
                    wr_q   <= seg_writable;
                    stk_q  <= seg_is_stack;
                end
                ST_RR_WR_A: if (pa_q == pb_q) vb_q <= wr_a_val;
                ST_CHECK:   vec_q <= chk_vec;
                ST_LK_RD:   if (mem_ack) mem_q <= opnd_get(mem_rdata, sz_q, 1'b0);
                default: ;
            endcase
        end
    end

    // Next state and outputs
    always_comb begin
        nstate    = state;
        rf_we     = 1'b0;
        rf_waddr  = pa_q;
        rf_wdata  = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        bus_lock  = 1'b0;
        done      = 1'b0;
        fault     = 1'b0;
        fault_vec = '0;
        unique case (state)
            ST_IDLE: if (go) nstate = dec_mem ? ST_CHECK : ST_RR_WR_A;
            ST_RR_WR_A: begin
                rf_we    = 1'b1;
                rf_wdata = wr_a_val;
                nstate   = ST_RR_WR_B;
            end
            ST_RR_WR_B: begin
                rf_we    = 1'b1;
                rf_waddr = pb_q;
                rf_wdata = opnd_put(vb_q, opnd_get(va_q, sz_q, ha_q), sz_q, hb_q);
                nstate   = ST_COMPLETE;
            end
            ST_CHECK: nstate = chk_flt ? ST_FAULT : ST_LK_RD;
            ST_LK_RD: begin
                mem_req  = 1'b1;
                bus_lock = 1'b1;
                if (mem_ack) nstate = ST_LK_WR;
            end
            ST_LK_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                bus_lock  = 1'b1;
                mem_wdata = opnd_get(va_q, sz_q, ha_q);
                if (mem_ack) nstate = ST_REG_WB;
            end
            ST_REG_WB: begin
                rf_we    = 1'b1;
                rf_wdata = opnd_put(va_q, mem_q, sz_q, ha_q);
                nstate   = ST_COMPLETE;
            end
            ST_COMPLETE: begin
                done   = 1'b1;
                nstate = ST_IDLE;
            end
            ST_FAULT: begin
                fault     = 1'b1;
                fault_vec = vec_q;
                nstate    = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/xchg_unit_chk.sv
module xchg_unit_chk #(
    parameter int ADDR_W = 32
)(
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [31:0]       mem_wdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              bus_lock,
    input logic              rf_we,
    input logic              done,
    input logic              fault
);
    AST_LOCK_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> bus_lock); // R5

    AST_LOCK_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && !(mem_req && mem_we && mem_ack)) |=> bus_lock); // R5

    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=>
            (mem_req && mem_we && $stable(mem_wdata) && $stable(mem_addr))); // R4

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> !mem_we); // R4

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!rf_we && !mem_req && !bus_lock && !done)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

endmodule

bind xchg_unit xchg_unit_chk #(.ADDR_W(ADDR_W)) u_xchg_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_wdata (mem_wdata),
    .mem_addr  (mem_addr),
    .bus_lock  (bus_lock),
    .rf_we     (rf_we),
    .done      (done),
    .fault     (fault)
);

// File: tb/xchg_unit_test.sv
`timescale 1ns/1ps
module xchg_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  modrm = 8'h00;
    logic        opsize32 = 1'b0;
    logic        real_mode = 1'b0;
    logic        seg_writable = 1'b1;
    logic        seg_is_stack = 1'b0;
    logic [31:0] seg_limit = 32'hFFFF_FFFF;
    logic [31:0] mem_offset = 32'h0;
    logic [2:0]  rf_raddr_a, rf_raddr_b, rf_waddr;
    logic [31:0] rf_rdata_a, rf_rdata_b, rf_wdata;
    logic        rf_we, mem_req, mem_we, mem_ack, bus_lock, done, fault;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic [7:0]  fault_vec;

    always #2.5 clk = ~clk;

    xchg_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .modrm(modrm),
        .opsize32(opsize32), .real_mode(real_mode), .seg_writable(seg_writable),
        .seg_is_stack(seg_is_stack), .seg_limit(seg_limit), .mem_offset(mem_offset),
        .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .bus_lock(bus_lock), .done(done), .fault(fault), .fault_vec(fault_vec)
    );

    // Register file and memory models
    logic [31:0] regs [0:7];
    logic [31:0] er   [0:7];
    logic [7:0]  bmem [0:255];
    int          wait_cfg = 0;
    int          wcnt = 0;
    int          we_tot = 0, req_tot = 0, lock_tot = 0, lock_bad = 0;
    int          checks = 0, errors = 0;

    assign rf_rdata_a = regs[rf_raddr_a];
    assign rf_rdata_b = regs[rf_raddr_b];
    assign mem_ack    = mem_req && (wcnt >= wait_cfg);
    assign mem_rdata  = {bmem[8'(mem_addr + 32'd3)], bmem[8'(mem_addr + 32'd2)],
                         bmem[8'(mem_addr + 32'd1)], bmem[8'(mem_addr)]};

    always @(posedge clk) begin
        if (rf_we) regs[rf_waddr] <= rf_wdata;
        if (mem_req && mem_we && mem_ack) begin
            bmem[8'(mem_addr)] <= mem_wdata[7:0];
            if (mem_size != 2'd0) bmem[8'(mem_addr + 32'd1)] <= mem_wdata[15:8];
            if (mem_size == 2'd2) begin
                bmem[8'(mem_addr + 32'd2)] <= mem_wdata[23:16];
                bmem[8'(mem_addr + 32'd3)] <= mem_wdata[31:24];
            end
        end
        if (!mem_req || mem_ack) wcnt <= 0;
        else                     wcnt <= wcnt + 1;
        if (rf_we)    we_tot   <= we_tot + 1;
        if (mem_req)  req_tot  <= req_tot + 1;
        if (bus_lock) lock_tot <= lock_tot + 1;
        if ((mem_req && !bus_lock) || (fault && bus_lock)) lock_bad <= lock_bad + 1;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Bench view of an operand: sz 0 byte, 1 word, 2 dword
    function automatic logic [31:0] get_op(input int idx, input int sz);
        if (sz == 0) return (idx < 4) ? {24'b0, er[idx][7:0]} : {24'b0, er[idx-4][15:8]};
        if (sz == 1) return {16'b0, er[idx][15:0]};
        return er[idx];
    endfunction

    task automatic put_op(input int idx, input int sz, input logic [31:0] v);
        if (sz == 0) begin
            if (idx < 4) er[idx][7:0] = v[7:0];
            else         er[idx-4][15:8] = v[7:0];
        end else if (sz == 1) er[idx][15:0] = v[15:0];
        else er[idx] = v;
    endtask

    task automatic seed_regs(input int s);
        for (int i = 0; i < 8; i++) begin
            regs[i] = 32'h9E37_79B9 * (i + 1) + 32'h0101_0101 * s;
            er[i]   = regs[i];
        end
    endtask

    task automatic cmp_regs(input string req, input string what);
        logic ok = 1'b1;
        int   bad = 0;
        for (int i = 0; i < 8; i++)
            if (regs[i] !== er[i]) begin
                if (ok) bad = i;
                ok = 1'b0;
            end
        chk(ok, req, what, regs[bad], er[bad]);
    endtask

    int          cyc;
    logic        fl;
    logic [7:0]  fv;
    int          we0, req0, lock0;

    task automatic run_op(input logic [7:0] op, input logic [7:0] mrm, input logic o32);
        @(negedge clk);
        opcode = op; modrm = mrm; opsize32 = o32; start = 1'b1;
        we0 = we_tot; req0 = req_tot; lock0 = lock_tot;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && !fault && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        fl = fault;
        fv = fault_vec;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seed_regs(0);
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        chk(!done && !fault && !bus_lock && !mem_req && !rf_we, "R6", "reset quiet",
            {27'b0, done, fault, bus_lock, mem_req, rf_we}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R12: short form, both sizes, including accumulator with itself
        for (int o = 0; o < 2; o++)
            for (int r = 0; r < 8; r++) begin
                logic [31:0] ta, tb;
                seed_regs(r + 8 * o);
                ta = get_op(0, 1 + o); tb = get_op(r, 1 + o);
                put_op(0, 1 + o, tb); put_op(r, 1 + o, ta);
                run_op(8'h90 + 8'(r), 8'h00, o[0]);
                cmp_regs(r == 0 ? "R12" : "R1", "short form regs");
                chk(cyc == 3 && !fl, "R6", "register swap latency", cyc, 3);
            end

        // R2: every byte pairing, register form
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
                logic [31:0] ta, tb;
                seed_regs(a * 8 + b);
                ta = get_op(a, 0); tb = get_op(b, 0);
                put_op(a, 0, tb); put_op(b, 0, ta);
                run_op(8'h86, {2'b11, 3'(a), 3'(b)}, 1'b0);
                cmp_regs(a == b ? "R12" : "R2", "byte swap regs");
            end

        // R3: every word/dword pairing
        for (int o = 0; o < 2; o++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++) begin
                    logic [31:0] ta, tb;
                    seed_regs(a + b + o);
                    ta = get_op(a, 1 + o); tb = get_op(b, 1 + o);
                    put_op(a, 1 + o, tb); put_op(b, 1 + o, ta);
                    run_op(8'h87, {2'b11, 3'(a), 3'(b)}, o[0]);
                    cmp_regs("R3", "word/dword swap regs");
                end

        // R4 / R5 / R6: memory swaps, all sizes, registers, wait counts
        real_mode = 1'b0; seg_writable = 1'b1; seg_limit = 32'h0000_FFFF;
        for (int sz = 0; sz < 3; sz++)
            for (int r = 0; r < 8; r++)
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] oldm, oldr, newm;
                    int base;
                    seed_regs(sz * 16 + r + w);
                    base = 64 + r * 8;
                    mem_offset = 32'(base);
                    wait_cfg = 2 * w;
                    oldm = {bmem[base + 3], bmem[base + 2], bmem[base + 1], bmem[base]};
                    if (sz == 0) oldm = oldm & 32'hFF; else if (sz == 1) oldm = oldm & 32'hFFFF;
                    oldr = get_op(r, sz);
                    put_op(r, sz, oldm);
                    run_op(sz == 0 ? 8'h86 : 8'h87, {2'b00, 3'(r), 3'b110}, sz == 2);
                    newm = {bmem[base + 3], bmem[base + 2], bmem[base + 1], bmem[base]};
                    if (sz == 0) newm = newm & 32'hFF; else if (sz == 1) newm = newm & 32'hFFFF;
                    cmp_regs("R4", "register after memory swap");
                    chk(newm == oldr, "R4", "memory after swap", newm, oldr);
                    chk(cyc == 5 + 4 * w && !fl, "R6", "memory swap latency", cyc, 5 + 4 * w);
                    chk(lock_tot - lock0 == 2 + 4 * w, "R5", "locked cycles",
                        lock_tot - lock0, 2 + 4 * w);
                end
        wait_cfg = 0;
        chk(lock_bad == 0, "R5", "request without lock", lock_bad, 0);

        // R7: protected mode, non-writable segment
        seed_regs(3);
        seg_writable = 1'b0; mem_offset = 32'h10;
        run_op(8'h87, 8'h08, 1'b1);
        chk(fl && fv == 8'd13, "R7", "non-writable vector", {23'b0, fl, fv}, {23'b0, 1'b1, 8'd13});
        chk(we_tot == we0 && req_tot == req0 && lock_tot == lock0, "R10", "no side effect",
            we_tot - we0 + req_tot - req0, 0);
        chk(cyc == 2, "R10", "fault latency", cyc, 2);
        cmp_regs("R10", "registers after fault");

        // R8: real mode boundary, writability ignored
        real_mode = 1'b1;
        for (int k = 0; k < 6; k++) begin
            logic [31:0] offs [0:5];
            int          szs  [0:5];
            logic        expf [0:5];
            offs = '{32'hFFFF, 32'hFFFF, 32'hFFFE, 32'hFFFC, 32'hFFFD, 32'h0010};
            szs  = '{0, 1, 1, 2, 2, 2};
            expf = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
            seed_regs(k);
            mem_offset = offs[k];
            run_op(szs[k] == 0 ? 8'h86 : 8'h87, 8'h00, szs[k] == 2);
            chk(fl == expf[k] && (!fl || fv == 8'd13), "R8", "real-mode limit",
                {23'b0, fl, fv}, {23'b0, expf[k], expf[k] ? 8'd13 : 8'd0});
        end

        // R9: protected limit, general vs stack
        real_mode = 1'b0; seg_writable = 1'b1; seg_limit = 32'h100;
        for (int k = 0; k < 4; k++) begin
            seg_is_stack = k[0];
            mem_offset   = (k < 2) ? 32'hFD : 32'hFE;
            run_op(8'h87, 8'h00, 1'b1);
            if (k < 2)
                chk(!fl, "R9", "dword ending at limit", {31'b0, fl}, 0);
            else
                chk(fl && fv == (k[0] ? 8'd12 : 8'd13), "R9", "limit fault vector",
                    {23'b0, fl, fv}, {23'b0, 1'b1, k[0] ? 8'd12 : 8'd13});
        end
        seg_is_stack = 1'b0;

        // R11: other opcode ignored
        seed_regs(9);
        @(negedge clk);
        opcode = 8'h88; modrm = 8'hC1; start = 1'b1;
        we0 = we_tot; req0 = req_tot;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk(we_tot == we0 && req_tot == req0 && !done, "R11", "foreign opcode activity",
            we_tot - we0 + req_tot - req0, 0);
        cmp_regs("R11", "registers after foreign opcode");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule